// File: doc/BRIEF.md
# Pending Interrupt List Selector

The block looks at a small bank of interrupt list entries and finds the most urgent one that may be taken. Each entry is presented on flat input vectors. An entry has a virtual ID, an 8-bit priority, a group bit and a two-bit state. The selection is combinational across the bank. It honours the used-entry count, the state of each entry and the two per-group enables.

Two one-cycle strobes use the selection. An acknowledge strobe claims the winner, provided the requested group, the priority mask and the running priority all allow it. A query strobe only reports the winner's ID and changes nothing. Results are registered. A claim produces an entry-update output naming the index that must move to the active state, and a set-active request that carries the winner's priority and group to the active-priority tracker. Writing the entries is left to the surrounding logic.

Top module: `pend_list_sel`

## Requirements
- R1: The state field of each entry uses bit 0 for pending and bit 1 for active. Only an entry in state 2'b01 is a candidate; an entry in 2'b10 or 2'b11 is never selected.
- R2: A group-0 entry (group bit 0) is skipped while `grp0_en` is low, and a group-1 entry is skipped while `grp1_en` is low.
- R3: A lower priority value is more urgent. The winner has the lowest value strictly below 0xFF, and when priorities tie the lowest index wins.
- R4: When there is no candidate, both acknowledge and query return the spurious ID 1023.
- R5: An acknowledge returns 1023 and claims nothing in either of two cases: the winner's group differs from `req_grp`, or `prio_mask` is less than or equal to the winner's priority.
- R6: An acknowledge returns 1023 and claims nothing when `run_prio` is less than or equal to the winner's preemption level. The preemption level is the priority with its low bits cleared: `bpr0`+1 bits for group 0, or `bpr1` bits for group 1.
- R7: A successful acknowledge returns the winner's virtual ID and asserts `upd_valid` with `upd_idx` set to the winner's index, meaning that entry becomes state 2'b10. It also asserts `set_act_valid` with the winner's priority and group.
- R8: A query returns the winner's ID when its group matches `req_grp` and 1023 otherwise. It ignores the mask and the running priority, and it never asserts `upd_valid` or `set_act_valid`.
- R9: Only indices below `used_cnt` are scanned.
- R10: Results appear one cycle after the strobe, with `rsp_valid` high for exactly that cycle. If both strobes are high together, the acknowledge is served.
- R11: During and right after reset, `rsp_valid`, `upd_valid` and `set_act_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ack_req | input | 1 | Acknowledge strobe |
| query_req | input | 1 | Highest-pending query strobe |
| used_cnt | input | CNT_W | Number of entries in use |
| ent_vid | input | N*VID_W | Virtual IDs, entry i at [i*VID_W +: VID_W] |
| ent_prio | input | N*8 | Priorities, entry i at [8i +: 8] |
| ent_grp | input | N | Group bits |
| ent_state | input | N*2 | States, entry i at [2i +: 2] |
| grp0_en | input | 1 | Group 0 enable |
| grp1_en | input | 1 | Group 1 enable |
| prio_mask | input | 8 | Priority mask |
| req_grp | input | 1 | Group of the access |
| run_prio | input | 8 | Current running priority (0xFF idle) |
| bpr0 | input | 3 | Group 0 binary point |
| bpr1 | input | 3 | Group 1 binary point |
| rsp_valid | output | 1 | Result valid |
| rsp_id | output | VID_W | Returned interrupt ID |
| upd_valid | output | 1 | Entry at upd_idx moves to active |
| upd_idx | output | IDX_W | Index of the updated entry |
| set_act_valid | output | 1 | Set-active-priority request |
| set_act_prio | output | 8 | Priority for the request |
| set_act_grp | output | 1 | Group for the request |

## Verification
The assertions check three things on every cycle. A claim always comes with a response and a set-active request. A claimed entry was pending-only, in range, and under the mask in the cycle of its strobe. A lone query never produces an update. Only the bench's scenarios can show the rest: which entry wins among ties and mixed states, the cases where enables or `used_cnt` hide a more urgent entry, the exact boundaries of mask and running priority under both groups' binary-point rules, and that acknowledge wins over a simultaneous query.

// File: rtl/pend_list_sel.sv
module pend_list_sel #(
  parameter int N     = 8,
  parameter int VID_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ack_req,
  input  logic                       query_req,
  input  logic [$clog2(N+1)-1:0]     used_cnt,
  input  logic [N*VID_W-1:0]         ent_vid,
  input  logic [N*8-1:0]             ent_prio,
  input  logic [N-1:0]               ent_grp,
  input  logic [N*2-1:0]             ent_state,
  input  logic                       grp0_en,
  input  logic                       grp1_en,
  input  logic [7:0]                 prio_mask,
  input  logic                       req_grp,
  input  logic [7:0]                 run_prio,
  input  logic [2:0]                 bpr0,
  input  logic [2:0]                 bpr1,
  output logic                       rsp_valid,
  output logic [VID_W-1:0]           rsp_id,
  output logic                       upd_valid,
  output logic [$clog2(N)-1:0]       upd_idx,
  output logic                       set_act_valid,
  output logic [7:0]                 set_act_prio,
  output logic                       set_act_grp
);
  localparam int IDX_W = $clog2(N);
  localparam logic [VID_W-1:0] SPUR = VID_W'(1023);

  logic             win_found;
  logic [IDX_W-1:0] win_idx;
  logic [7:0]       win_prio;

  always_comb begin
    win_found = 1'b0;
    win_idx   = '0;
    win_prio  = 8'hFF;
    for (int i = 0; i < N; i++) begin
      if (i < int'(used_cnt) && ent_state[2*i +: 2] == 2'b01 &&
          (ent_grp[i] ? grp1_en : grp0_en) && ent_prio[8*i +: 8] < win_prio) begin
        win_found = 1'b1;
        win_idx   = IDX_W'(i);
        win_prio  = ent_prio[8*i +: 8];
      end
    end
  end

  wire             win_grp = ent_grp[win_idx];
  wire [VID_W-1:0] win_vid = ent_vid[win_idx*VID_W +: VID_W];
  wire [3:0]       shamt   = win_grp ? {1'b0, bpr1} : {1'b0, bpr0} + 4'd1;
  wire [7:0]       pre_lvl = win_prio & (8'hFF << shamt);
  wire             grp_ok  = win_found && (win_grp == req_grp);
  wire             ack_ok  = grp_ok && (prio_mask > win_prio) && (run_prio > pre_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_id        <= SPUR;
      upd_valid     <= 1'b0;
      upd_idx       <= '0;
      set_act_valid <= 1'b0;
      set_act_prio  <= 8'hFF;
      set_act_grp   <= 1'b0;
    end else begin
      rsp_valid     <= ack_req | query_req;
      upd_valid     <= ack_req & ack_ok;
      set_act_valid <= ack_req & ack_ok;
      if (ack_req)
        rsp_id <= ack_ok ? win_vid : SPUR;
      else if (query_req)
        rsp_id <= grp_ok ? win_vid : SPUR;
      if (ack_req & ack_ok) begin
        upd_idx      <= win_idx;
        set_act_prio <= win_prio;
        set_act_grp  <= win_grp;
      end
    end
  end
endmodule

module pend_list_sel_chk #(
  parameter int N     = 8,
  parameter int VID_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ack_req,
  input logic                   query_req,
  input logic [$clog2(N+1)-1:0] used_cnt,
  input logic [N*8-1:0]         ent_prio,
  input logic [N*2-1:0]         ent_state,
  input logic [7:0]             prio_mask,
  input logic                   req_grp,
  input logic                   rsp_valid,
  input logic                   upd_valid,
  input logic [$clog2(N)-1:0]   upd_idx,
  input logic                   set_act_valid,
  input logic [7:0]             set_act_prio,
  input logic                   set_act_grp
);
  logic [N*2-1:0] state_q;
  logic [N*8-1:0] prio_q;
  always_ff @(posedge clk) begin
    state_q <= ent_state;
    prio_q  <= ent_prio;
  end

  p_claim_pairs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> set_act_valid && rsp_valid);
  p_claim_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> state_q[2*upd_idx +: 2] == 2'b01);
  p_claim_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> set_act_prio == prio_q[8*upd_idx +: 8]);
  p_claim_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $past(prio_mask) > set_act_prio);
  p_claim_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> set_act_grp == $past(req_grp));
  p_claim_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> int'(upd_idx) < int'($past(used_cnt)));
  p_query_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (query_req && !ack_req) |=> !upd_valid && !set_act_valid);
  p_rsp_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req || query_req) |=> rsp_valid);
endmodule

bind pend_list_sel pend_list_sel_chk #(.N(N), .VID_W(VID_W)) u_chk (.*);

// File: tb/sim_pend_list_sel.sv
module sim_pend_list_sel;
  localparam int N = 8;
  localparam int VID_W = 16;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic ack_req = 0, query_req = 0;
  logic [3:0] used_cnt = 4'd8;
  logic [N*VID_W-1:0] ent_vid;
  logic [N*8-1:0] ent_prio;
  logic [N-1:0] ent_grp;
  logic [N*2-1:0] ent_state;
  logic grp0_en = 1, grp1_en = 1, req_grp = 0;
  logic [7:0] prio_mask = 8'hFF, run_prio = 8'hFF;
  logic [2:0] bpr0 = 0, bpr1 = 0;
  logic rsp_valid, upd_valid, set_act_valid, set_act_grp;
  logic [VID_W-1:0] rsp_id;
  logic [2:0] upd_idx;
  logic [7:0] set_act_prio;

  logic [15:0] vid[N];
  logic [7:0]  pr[N];
  logic        g[N];
  logic [1:0]  st[N];
  always_comb
    for (int i = 0; i < N; i++) begin
      ent_vid[i*VID_W +: VID_W] = vid[i];
      ent_prio[8*i +: 8] = pr[i];
      ent_grp[i] = g[i];
      ent_state[2*i +: 2] = st[i];
    end

  pend_list_sel #(.N(N), .VID_W(VID_W)) u0 (.*);

  typedef struct {
    logic [15:0] id; logic upd; logic [2:0] idx; logic [7:0] prio; logic grp; string tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic exp_t model(bit is_ack, string tag);
    exp_t e;
    bit found = 0;
    logic [7:0] best = 8'hFF, pre;
    int wi = 0;
    for (int i = 0; i < N; i++)
      if (i < int'(used_cnt) && st[i] == 2'b01 && (g[i] ? grp1_en : grp0_en) && pr[i] < best) begin
        found = 1; best = pr[i]; wi = i;
      end
    pre = g[wi] ? (pr[wi] & (8'hFF << bpr1)) : (pr[wi] & (8'hFF << (bpr0 + 1)));
    e.tag = tag; e.upd = 0; e.idx = 3'(wi); e.prio = best; e.grp = g[wi]; e.id = 16'd1023;
    if (found && g[wi] == req_grp) begin
      if (!is_ack) e.id = vid[wi];
      else if (prio_mask > best && run_prio > pre) begin e.id = vid[wi]; e.upd = 1; end
    end
    return e;
  endfunction

  task automatic op(bit a, bit qy, string tag);
    exp_t e;
    @(negedge clk);
    e = model(a, tag);
    q.push_back(e);
    ack_req = a; query_req = qy;
    @(negedge clk);
    ack_req = 0; query_req = 0;
    if (e.upd) st[e.idx] = 2'b10;
  endtask

  always @(negedge clk) if (rst_n && rsp_valid) begin
    exp_t e;
    checks++;
    if (q.size() == 0) begin
      fails++; $display("FAIL R10: unexpected response id=%0d expected none", rsp_id);
    end else begin
      e = q.pop_front();
      if (rsp_id !== e.id || upd_valid !== e.upd || set_act_valid !== e.upd ||
          (e.upd && (upd_idx !== e.idx || set_act_prio !== e.prio || set_act_grp !== e.grp))) begin
        fails++;
        $display("FAIL %s: id=%0d upd=%0b idx=%0d prio=%h grp=%0b expected id=%0d upd=%0b idx=%0d prio=%h grp=%0b",
                 e.tag, rsp_id, upd_valid, upd_idx, set_act_prio, set_act_grp,
                 e.id, e.upd, e.idx, e.prio, e.grp);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin vid[i] = 16'h20 + 16'(i); g[i] = 0; st[i] = 2'b00; end
    pr[0] = 8'h80; pr[1] = 8'h60; pr[2] = 8'h90; pr[3] = 8'h60;
    pr[4] = 8'hA0; pr[5] = 8'hB0; pr[6] = 8'hC0; pr[7] = 8'h20;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || upd_valid !== 0 || set_act_valid !== 0) begin
      fails++; $display("FAIL R11: outputs %0b%0b%0b expected 000", rsp_valid, upd_valid, set_act_valid);
    end
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || upd_valid !== 0 || set_act_valid !== 0) begin
      fails++; $display("FAIL R11: after reset %0b%0b%0b expected 000", rsp_valid, upd_valid, set_act_valid);
    end

    op(0, 1, "R4 query empty");
    op(1, 0, "R4 ack empty");
    for (int i = 0; i < N; i++) st[i] = 2'b01;
    op(0, 1, "R3 lowest prio");
    used_cnt = 4'd7;
    op(0, 1, "R9 R3 used count and tie");
    req_grp = 1;
    op(0, 1, "R8 query group mismatch");
    req_grp = 0;
    st[1] = 2'b11; st[3] = 2'b10;
    op(0, 1, "R1 active skipped");
    g[0] = 1; grp1_en = 0;
    op(0, 1, "R2 group1 disabled");
    grp1_en = 1; grp0_en = 0; req_grp = 1;
    op(0, 1, "R2 group0 disabled");
    grp0_en = 1; req_grp = 0; g[0] = 0; st[1] = 2'b01; st[3] = 2'b01;
    prio_mask = 8'h60;
    op(1, 0, "R5 mask equal");
    prio_mask = 8'h61; req_grp = 1;
    op(1, 0, "R5 group mismatch");
    req_grp = 0; bpr0 = 3'd2; run_prio = 8'h60;
    op(1, 0, "R6 running equal preemption g0");
    run_prio = 8'h61;
    op(1, 0, "R7 ack success");
    prio_mask = 8'hFF; run_prio = 8'hFF;
    op(0, 1, "R7 claimed entry now active");
    g[3] = 1; pr[3] = 8'h2C; bpr1 = 3'd3; req_grp = 1; run_prio = 8'h28;
    op(1, 0, "R6 running equal preemption g1");
    run_prio = 8'h29;
    op(1, 0, "R6 g1 preemption success");
    req_grp = 0; run_prio = 8'hFF;
    op(1, 1, "R10 ack wins over query");
    op(0, 1, "R8 query leaves state");
    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++; $display("FAIL R10: %0d responses missing expected 0", q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule